// File: doc/BRIEF.md
# Configuration Port Access Unit

This block gives a host a port-mapped path into the configuration header of one modelled function. Software first loads a 32-bit selector through the selector window (port offsets 0 to 3). The selector carries an enable flag, a bus, device and function number, and a dword register index. Software then reads or writes the selected header dword through the data window (port offsets 4 to 7). Byte, word and dword accesses are all accepted. A sub-dword write is merged into the selected dword, and the other lanes keep their old values.

The header is a file of sixteen 32-bit dwords. Reset loads it from parameters. Six base address slots (dwords 4 to 9) and one expansion ROM slot (dword 12) each own a parameterised size mask. While the header-type field is zero, every write to one of these slots is ANDed with its mask. Software can therefore size a region by writing all ones and reading the result back. A selector that is disabled, or that names another bus, device or function, reads as all ones and does not accept writes.

The bus is a simple synchronous request port. A read request returns its data, with a one-cycle valid pulse, on the clock edge after the request.

Top module: `cfg_port_unit`

## Requirements
- R1: After reset the selector reads 0, the read-valid output is low, and the header dwords hold their parameterised initial values.
- R2: A dword write at port offset 0 loads the selector, and a dword read at offset 0 returns it. Every read request (io_req=1, io_wr=0) produces io_rvalid=1 with its data exactly one clock later. Without a read request, io_rvalid is 0.
- R3: Byte reads at offsets 0, 2 and 3 return 0x000000FF. Word reads at offsets 0 to 3 return 0x0000FFFF. Byte and word writes at offsets 0 to 3 leave the selector unchanged.
- R4: A byte read at offset 1 returns 0, and a byte write at offset 1 changes nothing.
- R5: The selector fields are: enable at bit 31, bus at bits 23:16, device at bits 15:11, function at bits 10:8, and dword index at bits 7:2. Bits 1:0 do not affect which dword is selected.
- R6: A data-window read returns 0xFFFFFFFF in the selected lanes when the enable bit is 0 or when bus, device or function differ from the parameters.
- R7: A data-window write is dropped when the enable bit is 0, when the target does not match, or when the selector equals exactly 0x80000000. Otherwise the write updates the selected dword.
- R8: Size code 0 is a byte access. A byte data access uses lane (offset mod 4). A read returns that byte zero-extended. A write replaces only that byte.
- R9: Size code 1 is a word access. A word data access shifts by 16 when offset bit 1 is set and by 0 otherwise. A read returns the 16-bit value zero-extended. A write replaces only those 16 bits.
- R10: While bits 22:16 of dword 3 are zero, a write to dwords 4 to 9 is ANDed with that slot's size mask, and a write to dword 12 is ANDed with the ROM size mask. A slot whose mask is zero reads 0 after a write.
- R11: While bits 22:16 of dword 3 are non-zero, writes to the address slots are stored unmasked.
- R12: Size code 2 is a dword access. A dword access at offsets 1 to 3 or 5 to 7, or any access with size code 3, reads 0xFFFFFFFF and writes nothing.
- R13: An enabled, matching selector with a dword index of 16 to 63 reads 0, and writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | Access request for this cycle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_port | input | 3 | Port offset: 0-3 selector window, 4-7 data window |
| io_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| io_wdata | input | 32 | Write data, right-aligned for byte and word |
| io_rdata | output | 32 | Read data, zero-extended for byte and word |
| io_rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
The same header dword is accessed as a dword, as four separate bytes and as two words. This separates a lane-selection error from a merge error, because each lane carries a distinct value. Selectors are varied one field at a time: enable cleared, foreign bus, foreign device, the exact enable-only value, stray low bits, and out-of-range indices. Each case isolates one condition of the match and write-permission logic. All-ones writes to the address slots are made with the header type both zero and non-zero, which shows the masking and its bypass. Sub-dword and misaligned accesses to the selector window show that the selector survives every path except an aligned dword write.

// File: rtl/cfg_port_pkg.sv
`timescale 1ns/1ps
package cfg_port_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } cfg_size_e;

    typedef struct packed {
        logic       en;
        logic [6:0] rsvd;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] idx;
        logic [1:0] low;
    } cfg_sel_t;

    localparam logic [31:0] CFG_ALL_ONES  = 32'hFFFF_FFFF;
    localparam logic [31:0] CFG_EN_ONLY   = 32'h8000_0000;
    localparam int          CFG_BAR_COUNT = 6;

endpackage

// File: rtl/cfg_target_match.sv
`timescale 1ns/1ps
module cfg_target_match
    import cfg_port_pkg::*;
#(
    parameter logic [7:0] BUS_ID = 8'd0,
    parameter logic [4:0] DEV_ID = 5'd0,
    parameter logic [2:0] FN_ID  = 3'd0
) (
    input  cfg_sel_t    sel,
    output logic        hit,
    output logic        wr_ok,
    output logic [5:0]  idx
);

    always_comb begin
        hit   = sel.en && (sel.bus == BUS_ID) && (sel.dev == DEV_ID) && (sel.fn == FN_ID);
        wr_ok = hit && (sel != cfg_sel_t'(CFG_EN_ONLY));
        idx   = sel.idx;
    end

endmodule

// File: rtl/cfg_lane_merge.sv
`timescale 1ns/1ps
module cfg_lane_merge
    import cfg_port_pkg::*;
(
    input  cfg_size_e   size,
    input  logic [1:0]  lane,
    input  logic [31:0] cur,
    input  logic [31:0] wdata,
    output logic [31:0] rd_val,
    output logic [31:0] merged
);

    logic [4:0]  shift_b;
    logic [4:0]  shift_w;
    logic [31:0] keep_b;
    logic [31:0] keep_w;

    always_comb begin
        shift_b = {lane, 3'b000};
        shift_w = {lane[1], 4'b0000};
        keep_b  = ~(32'h0000_00FF << shift_b);
        keep_w  = ~(32'h0000_FFFF << shift_w);
        case (size)
            SZ_BYTE: begin
                rd_val = (cur >> shift_b) & 32'h0000_00FF;
                merged = (cur & keep_b) | ((wdata & 32'h0000_00FF) << shift_b);
            end
            SZ_WORD: begin
                rd_val = (cur >> shift_w) & 32'h0000_FFFF;
                merged = (cur & keep_w) | ((wdata & 32'h0000_FFFF) << shift_w);
            end
            default: begin
                rd_val = cur;
                merged = wdata;
            end
        endcase
    end

endmodule

// File: rtl/cfg_header_file.sv
`timescale 1ns/1ps
module cfg_header_file
    import cfg_port_pkg::*;
#(
    parameter int NUM_DW    = 16,
    parameter int IDX_W     = 6,
    parameter int BAR_FIRST = 4,
    parameter int ROM_IDX   = 12,
    parameter int TYPE_IDX  = 3,
    parameter logic [NUM_DW-1:0][31:0]        INIT     = '0,
    parameter logic [CFG_BAR_COUNT-1:0][31:0] BAR_MASK = '0,
    parameter logic [31:0]                    ROM_MASK = 32'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);

    localparam int               SLOT_W   = $clog2(NUM_DW);
    localparam logic [IDX_W-1:0] DW_LIMIT = IDX_W'(NUM_DW);

    typedef struct packed {
        logic [NUM_DW-1:0][31:0] mem;
    } hf_state_t;

    hf_state_t st_d, st_q;

    logic [CFG_BAR_COUNT-1:0] bar_sel;
    logic                     type_zero;
    logic [31:0]              wr_mask;

    for (genvar b = 0; b < CFG_BAR_COUNT; b++) begin : g_bar_sel
        assign bar_sel[b] = (wr_idx == IDX_W'(BAR_FIRST + b));
    end

    always_comb begin
        type_zero = (st_q.mem[TYPE_IDX][22:16] == 7'd0);
        wr_mask   = CFG_ALL_ONES;
        if (type_zero) begin
            for (int b = 0; b < CFG_BAR_COUNT; b++) begin
                if (bar_sel[b]) wr_mask = BAR_MASK[b];
            end
            if (wr_idx == IDX_W'(ROM_IDX)) wr_mask = ROM_MASK;
        end
        st_d = st_q;
        if (wr_en && (wr_idx < DW_LIMIT)) begin
            st_d.mem[wr_idx[SLOT_W-1:0]] = wr_data & wr_mask;
        end
        rd_data = (rd_idx < DW_LIMIT) ? st_q.mem[rd_idx[SLOT_W-1:0]] : 32'h0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.mem <= INIT;
        else        st_q     <= st_d;
    end

    // R10: masked slot keeps no bits outside its size mask
    a_r10_bar0_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(BAR_FIRST) && st_q.mem[TYPE_IDX][22:16] == 7'd0)
        |=> ((st_q.mem[BAR_FIRST] & ~BAR_MASK[0]) == 32'h0));

    a_r10_rom_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(ROM_IDX) && st_q.mem[TYPE_IDX][22:16] == 7'd0)
        |=> ((st_q.mem[ROM_IDX] & ~ROM_MASK) == 32'h0));

    // R13: out-of-range index never disturbs the file
    a_r13_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= DW_LIMIT) |=> $stable(st_q.mem));

endmodule

// File: rtl/cfg_port_unit.sv
`timescale 1ns/1ps
module cfg_port_unit
    import cfg_port_pkg::*;
#(
    parameter logic [7:0]                     BUS_ID   = 8'd0,
    parameter logic [4:0]                     DEV_ID   = 5'd0,
    parameter logic [2:0]                     FN_ID    = 3'd0,
    parameter logic [15:0][31:0]              HDR_INIT = '0,
    parameter logic [CFG_BAR_COUNT-1:0][31:0] BAR_MASK = {32'hFFFF_FFFC, 32'hFFFF_FF00, 32'hFFFF_F000,
                                                          32'h0000_0000, 32'hFFFF_FFF1, 32'hFFFF_0000},
    parameter logic [31:0]                    ROM_MASK = 32'hFFFF_8001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_req,
    input  logic        io_wr,
    input  logic [2:0]  io_port,
    input  logic [1:0]  io_size,
    input  logic [31:0] io_wdata,
    output logic [31:0] io_rdata,
    output logic        io_rvalid
);

    localparam int NUM_DW = 16;
    localparam int IDX_W  = 6;

    typedef struct packed {
        cfg_sel_t    sel;
        logic [31:0] rdata;
        logic        rvalid;
    } top_state_t;

    top_state_t st_d, st_q;

    cfg_size_e   size;
    logic [1:0]  lane;
    logic        hit;
    logic        wr_ok;
    logic [5:0]  idx;
    logic [31:0] hf_rd;
    logic [31:0] cfg_dword;
    logic [31:0] lane_rd;
    logic [31:0] lane_wr;
    logic        hf_we;
    logic [31:0] rd_val;

    assign size = cfg_size_e'(io_size);
    assign lane = io_port[1:0];

    cfg_target_match #(
        .BUS_ID (BUS_ID),
        .DEV_ID (DEV_ID),
        .FN_ID  (FN_ID)
    ) u_match (
        .sel   (st_q.sel),
        .hit   (hit),
        .wr_ok (wr_ok),
        .idx   (idx)
    );

    assign cfg_dword = hit ? hf_rd : CFG_ALL_ONES;

    cfg_lane_merge u_lane (
        .size   (size),
        .lane   (lane),
        .cur    (cfg_dword),
        .wdata  (io_wdata),
        .rd_val (lane_rd),
        .merged (lane_wr)
    );

    cfg_header_file #(
        .NUM_DW   (NUM_DW),
        .IDX_W    (IDX_W),
        .INIT     (HDR_INIT),
        .BAR_MASK (BAR_MASK),
        .ROM_MASK (ROM_MASK)
    ) u_hdr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hf_we),
        .wr_idx  (idx),
        .wr_data (lane_wr),
        .rd_idx  (idx),
        .rd_data (hf_rd)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = io_req && !io_wr;
        hf_we       = 1'b0;
        rd_val      = CFG_ALL_ONES;
        if (io_req) begin
            if (!io_port[2]) begin
                case (size)
                    SZ_DWORD: if (lane == 2'd0) begin
                        rd_val = st_q.sel;
                        if (io_wr) st_d.sel = cfg_sel_t'(io_wdata);
                    end
                    SZ_BYTE:  rd_val = (lane == 2'd1) ? 32'h0 : 32'h0000_00FF;
                    SZ_WORD:  rd_val = 32'h0000_FFFF;
                    default:  rd_val = CFG_ALL_ONES;
                endcase
            end else begin
                case (size)
                    SZ_DWORD: if (lane == 2'd0) begin
                        rd_val = lane_rd;
                        hf_we  = io_wr && wr_ok;
                    end
                    SZ_BYTE, SZ_WORD: begin
                        rd_val = lane_rd;
                        hf_we  = io_wr && wr_ok;
                    end
                    default: rd_val = CFG_ALL_ONES;
                endcase
            end
            if (!io_wr) st_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel    <= cfg_sel_t'(32'h0);
            st_q.rdata  <= 32'h0;
            st_q.rvalid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_rdata  = st_q.rdata;
    assign io_rvalid = st_q.rvalid;

    // R2: one-cycle read response
    a_r2_read_response: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_wr) |=> io_rvalid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_req && !io_wr) |=> !io_rvalid);

    // R3: sub-dword selector writes never touch the selector
    a_r3_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && io_wr && !io_port[2] && io_size != 2'd2) |=> $stable(st_q.sel));

    // R4: control byte location reads zero
    a_r4_ctrl_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_wr && io_port == 3'd1 && io_size == 2'd0) |=> (io_rdata == 32'h0));

    // R6: disabled selector reads all ones
    a_r6_disabled_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_wr && io_port == 3'd4 && io_size == 2'd2 && !st_q.sel.en)
        |=> (io_rdata == CFG_ALL_ONES));

    // R12: misaligned dword data read yields all ones
    a_r12_misaligned_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_wr && io_port[2] && io_port[1:0] != 2'd0 && io_size == 2'd2)
        |=> (io_rdata == CFG_ALL_ONES));

endmodule

// File: tb/cfg_port_unit_bench.sv
`timescale 1ns/1ps
module cfg_port_unit_bench;

    localparam logic [15:0][31:0] B_INIT = {
        32'h0, 32'h0, 32'h0, 32'h0, 32'hC0DE_F00D, 32'h0, 32'h0, 32'h0,
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0300_0001, 32'h0, 32'h5A3C_1B2D};
    localparam logic [5:0][31:0] B_BAR = {
        32'hFFFF_FFFC, 32'hFFFF_FF00, 32'hFFFF_F000, 32'h0000_0000, 32'hFFFF_FFF1, 32'hFFFF_0000};
    localparam logic [31:0] B_ROM = 32'hFFFF_8001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0;
    logic        io_wr = 1'b0;
    logic [2:0]  io_port = 3'd0;
    logic [1:0]  io_size = 2'd0;
    logic [31:0] io_wdata = 32'h0;
    logic [31:0] io_rdata;
    logic        io_rvalid;
    string       cur_tag = "R1";

    int compared = 0;
    int mismatched = 0;
    bit seen_edge = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cfg_port_unit #(
        .BUS_ID (8'd0), .DEV_ID (5'd0), .FN_ID (3'd0),
        .HDR_INIT (B_INIT), .BAR_MASK (B_BAR), .ROM_MASK (B_ROM)
    ) u_cfg_port_unit (
        .clk (clk), .rst_n (rst_n), .io_req (io_req), .io_wr (io_wr),
        .io_port (io_port), .io_size (io_size), .io_wdata (io_wdata),
        .io_rdata (io_rdata), .io_rvalid (io_rvalid)
    );

    // behavioural reference model
    logic [31:0] m_sel;
    logic [31:0] m_hdr [16];
    logic        e_rv = 1'b0;
    logic [31:0] e_rd = 32'h0;
    string       e_tag = "R1";

    always @(posedge clk) begin
        logic [31:0] r, cur, nv;
        int k, sh;
        bit hitm, okw, dowr;
        seen_edge = 1'b1;
        if (!rst_n) begin
            m_sel = 32'h0;
            for (int i = 0; i < 16; i++) m_hdr[i] = B_INIT[i];
            e_rv = 1'b0;
        end else begin
            e_rv = 1'b0;
            if (io_req) begin
                r = 32'hFFFF_FFFF;
                if (io_port < 3'd4) begin
                    if (io_size == 2'd2 && io_port == 3'd0) begin
                        r = m_sel;
                        if (io_wr) m_sel = io_wdata;
                    end else if (io_size == 2'd0) r = (io_port == 3'd1) ? 32'h0 : 32'hFF;
                    else if (io_size == 2'd1) r = 32'hFFFF;
                end else begin
                    hitm = m_sel[31] && m_sel[23:8] == 16'h0;
                    k    = int'(m_sel[7:2]);
                    cur  = !hitm ? 32'hFFFF_FFFF : (k < 16 ? m_hdr[k] : 32'h0);
                    okw  = hitm && m_sel != 32'h8000_0000;
                    dowr = 1'b0;
                    nv   = cur;
                    if (io_size == 2'd2 && io_port == 3'd4) begin
                        r = cur; nv = io_wdata; dowr = 1'b1;
                    end else if (io_size == 2'd0) begin
                        sh = int'(io_port[1:0]) * 8;
                        r  = (cur >> sh) & 32'hFF;
                        nv = (cur & ~(32'hFF << sh)) | ((io_wdata & 32'hFF) << sh);
                        dowr = 1'b1;
                    end else if (io_size == 2'd1) begin
                        sh = io_port[1] ? 16 : 0;
                        r  = (cur >> sh) & 32'hFFFF;
                        nv = (cur & ~(32'hFFFF << sh)) | ((io_wdata & 32'hFFFF) << sh);
                        dowr = 1'b1;
                    end
                    if (io_wr && okw && dowr && k < 16) begin
                        if (m_hdr[3][22:16] == 7'd0) begin
                            if (k >= 4 && k <= 9) nv = nv & B_BAR[k-4];
                            if (k == 12) nv = nv & B_ROM;
                        end
                        m_hdr[k] = nv;
                    end
                end
                if (!io_wr) begin
                    e_rv = 1'b1; e_rd = r; e_tag = cur_tag;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (seen_edge && !done) begin
            compared++;
            if (io_rvalid !== e_rv || (e_rv && io_rdata !== e_rd)) begin
                mismatched++;
                $display("FAIL %s: rvalid=%0b rdata=%08h expected rvalid=%0b rdata=%08h",
                         e_tag, io_rvalid, io_rdata, e_rv, e_rd);
            end
        end
    end

    task automatic acc(input bit wr, input logic [2:0] port, input logic [1:0] size,
                       input logic [31:0] data, input string t);
        @(negedge clk);
        io_req = 1'b1; io_wr = wr; io_port = port; io_size = size; io_wdata = data; cur_tag = t;
        @(negedge clk);
        io_req = 1'b0; io_wr = 1'b0;
    endtask

    task automatic setsel(input logic [31:0] v, input string t);
        acc(1'b1, 3'd0, 2'd2, v, t);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        acc(1'b0, 3'd0, 2'd2, 0, "R1");
        setsel(32'h8000_0000, "R1");
        acc(1'b0, 3'd4, 2'd2, 0, "R1");
        setsel(32'h8000_002C, "R1");
        acc(1'b0, 3'd4, 2'd2, 0, "R1");
        // R2: selector load and read back
        setsel(32'h1234_5678, "R2");
        acc(1'b0, 3'd0, 2'd2, 0, "R2");
        // R5: low offset bits ignored
        setsel(32'h8000_000A, "R5");
        acc(1'b0, 3'd4, 2'd2, 0, "R5");
        // R6: disabled and mismatched targets
        setsel(32'h0000_0008, "R6");
        acc(1'b0, 3'd4, 2'd2, 0, "R6");
        acc(1'b0, 3'd5, 2'd0, 0, "R6");
        setsel(32'h8000_0808, "R6");
        acc(1'b0, 3'd4, 2'd2, 0, "R6");
        setsel(32'h8001_0008, "R6");
        acc(1'b0, 3'd4, 2'd2, 0, "R6");
        setsel(32'h8000_0108, "R6");
        acc(1'b0, 3'd6, 2'd1, 0, "R6");
        // R7: dropped and accepted writes
        setsel(32'h8000_0000, "R7");
        acc(1'b1, 3'd4, 2'd2, 32'hDEAD_BEEF, "R7");
        acc(1'b0, 3'd4, 2'd2, 0, "R7");
        setsel(32'h0000_0004, "R7");
        acc(1'b1, 3'd4, 2'd2, 32'h1111_2222, "R7");
        setsel(32'h8000_0804, "R7");
        acc(1'b1, 3'd4, 2'd2, 32'h3333_4444, "R7");
        setsel(32'h8000_0004, "R7");
        acc(1'b0, 3'd4, 2'd2, 0, "R7");
        acc(1'b1, 3'd4, 2'd2, 32'hA5A5_0F0F, "R7");
        acc(1'b0, 3'd4, 2'd2, 0, "R7");
        // R3: sub-dword selector window
        acc(1'b0, 3'd0, 2'd0, 0, "R3");
        acc(1'b0, 3'd2, 2'd0, 0, "R3");
        acc(1'b0, 3'd3, 2'd0, 0, "R3");
        acc(1'b0, 3'd0, 2'd1, 0, "R3");
        acc(1'b0, 3'd2, 2'd1, 0, "R3");
        acc(1'b1, 3'd0, 2'd0, 32'h55, "R3");
        acc(1'b1, 3'd2, 2'd1, 32'h7777, "R3");
        acc(1'b0, 3'd0, 2'd2, 0, "R3");
        // R4: control byte
        acc(1'b0, 3'd1, 2'd0, 0, "R4");
        acc(1'b1, 3'd1, 2'd0, 32'h06, "R4");
        acc(1'b0, 3'd0, 2'd2, 0, "R4");
        // R8: byte lanes
        for (int l = 0; l < 4; l++) acc(1'b1, 3'(4 + l), 2'd0, 32'h10 + 32'(l) * 32'h21, "R8");
        for (int l = 0; l < 4; l++) acc(1'b0, 3'(4 + l), 2'd0, 0, "R8");
        acc(1'b1, 3'd6, 2'd0, 32'hFFFF_FFEE, "R8");
        acc(1'b0, 3'd4, 2'd2, 0, "R8");
        // R9: word lanes
        acc(1'b1, 3'd6, 2'd1, 32'h0000_BEAD, "R9");
        acc(1'b1, 3'd5, 2'd1, 32'h0000_C001, "R9");
        acc(1'b0, 3'd5, 2'd1, 0, "R9");
        acc(1'b0, 3'd7, 2'd1, 0, "R9");
        acc(1'b0, 3'd4, 2'd2, 0, "R9");
        // R10: size masking
        for (int b = 0; b < 6; b++) begin
            setsel(32'h8000_0010 + 32'(b) * 4, "R10");
            acc(1'b1, 3'd4, 2'd2, 32'hFFFF_FFFF, "R10");
            acc(1'b0, 3'd4, 2'd2, 0, "R10");
        end
        setsel(32'h8000_0010, "R10");
        acc(1'b1, 3'd5, 2'd0, 32'h00, "R10");
        acc(1'b0, 3'd4, 2'd2, 0, "R10");
        setsel(32'h8000_0030, "R10");
        acc(1'b1, 3'd4, 2'd2, 32'hFFFF_FFFF, "R10");
        acc(1'b0, 3'd4, 2'd2, 0, "R10");
        // R11: non-zero header type bypasses masks
        setsel(32'h8000_000C, "R11");
        acc(1'b1, 3'd4, 2'd2, 32'h0001_0000, "R11");
        setsel(32'h8000_0018, "R11");
        acc(1'b1, 3'd4, 2'd2, 32'hFFFF_FFFF, "R11");
        acc(1'b0, 3'd4, 2'd2, 0, "R11");
        setsel(32'h8000_000C, "R11");
        acc(1'b1, 3'd4, 2'd2, 32'h0, "R11");
        setsel(32'h8000_0018, "R11");
        acc(1'b1, 3'd4, 2'd2, 32'hFFFF_FFFF, "R11");
        acc(1'b0, 3'd4, 2'd2, 0, "R11");
        // R12: misaligned dword and reserved size
        setsel(32'h8000_0004, "R12");
        acc(1'b0, 3'd5, 2'd2, 0, "R12");
        acc(1'b0, 3'd6, 2'd2, 0, "R12");
        acc(1'b0, 3'd7, 2'd2, 0, "R12");
        acc(1'b1, 3'd6, 2'd2, 32'h0BAD_0BAD, "R12");
        acc(1'b1, 3'd4, 2'd3, 32'h0BAD_0BAD, "R12");
        acc(1'b0, 3'd4, 2'd3, 0, "R12");
        acc(1'b0, 3'd1, 2'd2, 0, "R12");
        acc(1'b1, 3'd2, 2'd2, 32'h0, "R12");
        acc(1'b0, 3'd0, 2'd2, 0, "R12");
        acc(1'b0, 3'd4, 2'd2, 0, "R12");
        // R13: indices beyond the file
        setsel(32'h8000_0050, "R13");
        acc(1'b0, 3'd4, 2'd2, 0, "R13");
        acc(1'b1, 3'd4, 2'd2, 32'h1234_0000, "R13");
        acc(1'b0, 3'd4, 2'd2, 0, "R13");
        setsel(32'h8000_00FC, "R13");
        acc(1'b1, 3'd6, 2'd1, 32'hFFFF, "R13");
        acc(1'b0, 3'd4, 2'd2, 0, "R13");
        setsel(32'h8000_0000, "R13");
        acc(1'b0, 3'd4, 2'd2, 0, "R13");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog: rvalid=%0b expected run to complete", io_rvalid);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule